// File: doc/BRIEF.md
# State machine interrupt flag controller

This block gathers the interrupt-worthy conditions of an engine with four small state machines into one raw status word and drives a single interrupt line from it. Each state machine reports two levels, "receive queue holds data" and "transmit queue has room", and the low four of eight shared event flags are added to these. The raw word is gated by an enable register to form the masked status. A registered interrupt output goes high whenever any masked bit is set.

The eight event flags are set by one-cycle pulses from the state machines. The host changes the flags and the enable register through one write port that carries an operation code. The flag operations are a write-1-to-clear and a separate write-1-to-set force. The enable register can be loaded as a whole, or single bits can be set or cleared atomically without touching the others. The current enable and flag values are visible on output ports, so software can also do its own read-modify-write.

Top module: `sm_irq_ctrl`

## Requirements
- R1: raw_status[3:0] equals rx_not_empty[3:0] in the same cycle. The bit is a live level and is never latched.
- R2: raw_status[7:4] equals tx_not_full[3:0] in the same cycle, also as a live level.
- R3: raw_status[11:8] equals the current event flags[3:0].
- R4: masked_status equals raw_status AND irq_enable, bit for bit.
- R5: irq_o is 1 in the cycle after a cycle in which masked_status is nonzero, and 0 in the cycle after a cycle in which it is zero.
- R6: A 1 on flag_set[i] in a cycle makes flags[i] 1 from the next cycle on.
- R7: With wr_en high and wr_op = 3, every flag whose wr_data bit (bits 7:0) is 1 becomes 0 in the next cycle, and the other flags keep their value.
- R8: With wr_en high and wr_op = 4, every flag whose wr_data bit (bits 7:0) is 1 becomes 1 in the next cycle, and the other flags keep their value.
- R9: When flag_set[i] and a clear of the same flag (wr_op = 3) happen in the same cycle, flags[i] is 1 afterwards.
- R10: With wr_en high, wr_op = 0 loads irq_enable with wr_data[11:0], wr_op = 1 sets the enable bits where wr_data is 1, and wr_op = 2 clears them. Enable bits that are not selected are unchanged.
- R11: After reset, the flags, irq_enable and irq_o are all zero.
- R12: With wr_en high and wr_op of 5, 6 or 7, neither the flags nor irq_enable change. The same holds for any wr_op while wr_en is low. Flags still respond to flag_set in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_not_empty | input | 4 | Per state machine: receive queue holds data (level) |
| tx_not_full | input | 4 | Per state machine: transmit queue has room (level) |
| flag_set | input | 8 | One-cycle set pulses for the event flags, from the state machines |
| wr_en | input | 1 | Host write strobe |
| wr_op | input | 3 | Host operation: 0 load enable, 1 set enable bits, 2 clear enable bits, 3 clear flags, 4 force flags |
| wr_data | input | 12 | Host write data or bit mask |
| flags | output | 8 | Current event flags |
| irq_enable | output | 12 | Current enable register |
| raw_status | output | 12 | Raw status word |
| masked_status | output | 12 | Raw status gated by the enable register |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A state machine set pulse and a host clear can hit the same flag in the same cycle, and the set must win. The bench creates this collision in a directed step on one flag. It also lets random set pulses land on random clear masks throughout the run. In both cases the flags that follow are compared with a bench model in which the set is applied after the clear. The enable update and a flag change in the same cycle are judged the same way, through the masked status and the one-cycle delayed interrupt.

// File: rtl/sm_irq_pkg.sv
package sm_irq_pkg;

    typedef enum logic [2:0] {
        OP_EN_LOAD    = 3'd0,
        OP_EN_SET     = 3'd1,
        OP_EN_CLR     = 3'd2,
        OP_FLAG_CLR   = 3'd3,
        OP_FLAG_FORCE = 3'd4
    } host_op_e;

endpackage

// File: rtl/sm_irq_raw.sv
module sm_irq_raw #(
    parameter int NUM_SM = 4
) (
    input  logic [NUM_SM-1:0]   rx_lvl,
    input  logic [NUM_SM-1:0]   tx_lvl,
    input  logic [NUM_SM-1:0]   flag_lo,
    output logic [3*NUM_SM-1:0] raw
);

    // three groups of NUM_SM bits: receive, transmit, low flags
    for (genvar g = 0; g < NUM_SM; g++) begin : g_sm
        assign raw[g]            = rx_lvl[g];
        assign raw[NUM_SM + g]   = tx_lvl[g];
        assign raw[2*NUM_SM + g] = flag_lo[g];
    end

endmodule

// File: rtl/sm_evt_flags.sv
module sm_evt_flags #(
    parameter int NUM_FLAGS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_pulse,
    input  logic [NUM_FLAGS-1:0] clr_mask,
    input  logic [NUM_FLAGS-1:0] force_mask,
    output logic [NUM_FLAGS-1:0] flags
);

    typedef struct packed {
        logic [NUM_FLAGS-1:0] flags;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear first, then set pulses and force, so a set wins a collision
        st_d.flags = (st_q.flags & ~clr_mask) | set_pulse | force_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;

endmodule

// File: rtl/sm_irq_mask.sv
module sm_irq_mask
    import sm_irq_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_op,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] raw,
    output logic [W-1:0] enable,
    output logic [W-1:0] masked,
    output logic         irq
);

    typedef struct packed {
        logic [W-1:0] en;
        logic         irq;
    } mask_state_t;

    mask_state_t st_d, st_q;

    assign masked = raw & st_q.en;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |masked;
        if (wr_en) begin
            case (wr_op)
                OP_EN_LOAD: st_d.en = wr_data;
                OP_EN_SET:  st_d.en = st_q.en | wr_data;
                OP_EN_CLR:  st_d.en = st_q.en & ~wr_data;
                default:    st_d.en = st_q.en;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable = st_q.en;
    assign irq    = st_q.irq;

endmodule

// File: rtl/sm_irq_ctrl.sv
module sm_irq_ctrl
    import sm_irq_pkg::*;
#(
    parameter int NUM_SM    = 4,
    parameter int NUM_FLAGS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SM-1:0]     rx_not_empty,
    input  logic [NUM_SM-1:0]     tx_not_full,
    input  logic [NUM_FLAGS-1:0]  flag_set,
    input  logic                  wr_en,
    input  logic [2:0]            wr_op,
    input  logic [3*NUM_SM-1:0]   wr_data,
    output logic [NUM_FLAGS-1:0]  flags,
    output logic [3*NUM_SM-1:0]   irq_enable,
    output logic [3*NUM_SM-1:0]   raw_status,
    output logic [3*NUM_SM-1:0]   masked_status,
    output logic                  irq_o
);

    localparam int RAW_W = 3 * NUM_SM;

    logic [NUM_FLAGS-1:0] clr_mask, force_mask, flag_bits;

    always_comb begin
        clr_mask   = '0;
        force_mask = '0;
        if (wr_en && wr_op == OP_FLAG_CLR)   clr_mask   = wr_data[NUM_FLAGS-1:0];
        if (wr_en && wr_op == OP_FLAG_FORCE) force_mask = wr_data[NUM_FLAGS-1:0];
    end

    sm_evt_flags #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_pulse  (flag_set),
        .clr_mask   (clr_mask),
        .force_mask (force_mask),
        .flags      (flag_bits)
    );

    sm_irq_raw #(.NUM_SM(NUM_SM)) u_raw (
        .rx_lvl  (rx_not_empty),
        .tx_lvl  (tx_not_full),
        .flag_lo (flag_bits[NUM_SM-1:0]),
        .raw     (raw_status)
    );

    sm_irq_mask #(.W(RAW_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_op   (wr_op),
        .wr_data (wr_data),
        .raw     (raw_status),
        .enable  (irq_enable),
        .masked  (masked_status),
        .irq     (irq_o)
    );

    assign flags = flag_bits;

endmodule

// File: rtl/sm_irq_ctrl_chk.sv
module sm_irq_ctrl_chk #(
    parameter int NUM_SM    = 4,
    parameter int NUM_FLAGS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_FLAGS-1:0] flag_set,
    input logic                 wr_en,
    input logic [2:0]           wr_op,
    input logic [3*NUM_SM-1:0]  wr_data,
    input logic [NUM_FLAGS-1:0] flags,
    input logic [3*NUM_SM-1:0]  irq_enable,
    input logic [3*NUM_SM-1:0]  raw_status,
    input logic [3*NUM_SM-1:0]  masked_status,
    input logic                 irq_o
);

    AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_status & ~raw_status) == '0); // R4

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|masked_status) |=> irq_o); // R5

    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(|masked_status) |=> !irq_o); // R5

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_set != '0) |=> ((flags & $past(flag_set)) == $past(flag_set))); // R6

    AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 3'd3) |=>
        ((flags & $past(wr_data[NUM_FLAGS-1:0] & ~flag_set)) == '0)); // R7

    AST_FORCE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 3'd4) |=>
        ((flags & $past(wr_data[NUM_FLAGS-1:0])) == $past(wr_data[NUM_FLAGS-1:0]))); // R8

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 3'd3 && (flag_set & wr_data[NUM_FLAGS-1:0]) != '0) |=>
        ((flags & $past(flag_set & wr_data[NUM_FLAGS-1:0])) != '0)); // R9

    AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 3'd1) |=> ((irq_enable & $past(wr_data)) == $past(wr_data))); // R10

    AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == 3'd2) |=> ((irq_enable & $past(wr_data)) == '0)); // R10

    AST_IGNORED_OP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op >= 3'd5) |=> $stable(irq_enable)); // R12

endmodule

bind sm_irq_ctrl sm_irq_ctrl_chk #(.NUM_SM(NUM_SM), .NUM_FLAGS(NUM_FLAGS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flag_set      (flag_set),
    .wr_en         (wr_en),
    .wr_op         (wr_op),
    .wr_data       (wr_data),
    .flags         (flags),
    .irq_enable    (irq_enable),
    .raw_status    (raw_status),
    .masked_status (masked_status),
    .irq_o         (irq_o)
);

// File: tb/test_sm_irq_ctrl.sv
`timescale 1ns/1ps
module test_sm_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rx_not_empty = '0, tx_not_full = '0;
    logic [7:0]  flag_set = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_op = '0;
    logic [11:0] wr_data = '0;
    logic [7:0]  flags;
    logic [11:0] irq_enable, raw_status, masked_status;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  exp_flags = '0;
    logic [11:0] exp_en = '0;
    logic        exp_irq = 1'b0;
    string       ftag = "R11", etag = "R11", itag = "R11";

    always #4 clk = ~clk;

    sm_irq_ctrl i_sm_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_not_empty(rx_not_empty), .tx_not_full(tx_not_full),
        .flag_set(flag_set), .wr_en(wr_en), .wr_op(wr_op), .wr_data(wr_data),
        .flags(flags), .irq_enable(irq_enable), .raw_status(raw_status),
        .masked_status(masked_status), .irq_o(irq_o)
    );

    task automatic check(input string tag, input string what, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] next_flags(input logic [7:0] f, input logic [7:0] s,
                                              input logic we, input logic [2:0] op, input logic [11:0] d);
        logic [7:0] clr = (we && op == 3'd3) ? d[7:0] : 8'h00;
        logic [7:0] frc = (we && op == 3'd4) ? d[7:0] : 8'h00;
        return (f & ~clr) | s | frc;
    endfunction

    function automatic logic [11:0] next_en(input logic [11:0] e, input logic we,
                                            input logic [2:0] op, input logic [11:0] d);
        if (!we) return e;
        case (op)
            3'd0: return d;
            3'd1: return e | d;
            3'd2: return e & ~d;
            default: return e;
        endcase
    endfunction

    // one cycle: check registered state, drive, check combinational, advance model
    task automatic step(input logic [3:0] rx, input logic [3:0] tx, input logic [7:0] s,
                        input logic we, input logic [2:0] op, input logic [11:0] d);
        logic [11:0] exp_raw;
        @(negedge clk);
        check(ftag, "flags", {4'h0, flags}, {4'h0, exp_flags});
        check(etag, "irq_enable", irq_enable, exp_en);
        check(itag, "irq_o", {11'h0, irq_o}, {11'h0, exp_irq});
        rx_not_empty = rx; tx_not_full = tx; flag_set = s;
        wr_en = we; wr_op = op; wr_data = d;
        #1;
        exp_raw = {exp_flags[3:0], tx, rx};
        check("R1", "raw rx group", {8'h0, raw_status[3:0]}, {8'h0, rx});
        check("R2", "raw tx group", {8'h0, raw_status[7:4]}, {8'h0, tx});
        check("R3", "raw flag group", {8'h0, raw_status[11:8]}, {8'h0, exp_flags[3:0]});
        check("R4", "masked_status", masked_status, exp_raw & exp_en);
        exp_irq = |(exp_raw & exp_en);
        itag = "R5";
        if (we && op == 3'd3 && (s & d[7:0]) != 0) ftag = "R9";
        else if (we && op == 3'd3) ftag = "R7";
        else if (we && op == 3'd4) ftag = "R8";
        else if (we && op >= 3'd5) ftag = "R12";
        else ftag = "R6";
        etag = (we && op <= 3'd2) ? "R10" : "R12";
        exp_flags = next_flags(exp_flags, s, we, op, d);
        exp_en = next_en(exp_en, we, op, d);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #20;
        rst_n = 1'b1;
        // reset state
        step(4'h0, 4'h0, 8'h00, 1'b0, 3'd0, 12'h000);
        // R10: load, set, clear enable bits
        step(4'h0, 4'h0, 8'h00, 1'b1, 3'd0, 12'h00F);
        step(4'h5, 4'h0, 8'h00, 1'b1, 3'd1, 12'h300);
        step(4'h0, 4'h0, 8'h00, 1'b1, 3'd2, 12'h00A);
        // R6: set pulses on flags 0 and 6
        step(4'h1, 4'h0, 8'h41, 1'b0, 3'd0, 12'h000);
        // R9: set on flag 1 together with clear of flags 0,1
        step(4'h0, 4'h0, 8'h02, 1'b1, 3'd3, 12'h003);
        // R8: force flags 2 and 7
        step(4'h0, 4'hF, 8'h00, 1'b1, 3'd4, 12'h084);
        // R12: ignored op codes
        step(4'h0, 4'h0, 8'h00, 1'b1, 3'd5, 12'hFFF);
        step(4'h0, 4'h0, 8'h00, 1'b1, 3'd7, 12'hFFF);
        // R7: clear everything
        step(4'h0, 4'h0, 8'h00, 1'b1, 3'd3, 12'h0FF);
        step(4'h0, 4'h0, 8'h00, 1'b0, 3'd0, 12'h000);
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] s;
            s = 8'($urandom) & 8'($urandom) & 8'($urandom);
            step(4'($urandom), 4'($urandom), s, 1'($urandom), 3'($urandom), 12'($urandom));
        end
        step(4'h0, 4'h0, 8'h00, 1'b0, 3'd0, 12'h000);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule